// File: doc/BRIEF.md
# Serial Configuration Daisy-Chain Receiver

This block is the configuration front end of a programmable device loaded in slave-serial fashion. A single data bit arrives on each rising edge of a configuration clock that is driven from outside. The block takes in a fixed number of bits for its own configuration, given by a parameter. It groups them into words for the local configuration store. Once that number is reached it becomes a one-stage pass-through: every later bit is re-timed and driven out to the next device in a chain.

Bits are taken only while two conditions hold. The mode inputs must select slave-serial operation, and the init-ready line shared by all devices in the chain must be high. At the board level the mode inputs carry pull-ups, so if they are left open they read 111 and select slave-serial by default. The default length is 3,430,400 bits. The counter is sized from that parameter, so smaller lengths work as well.

Top module: `cfg_chain_rx`

## Requirements
- R1: A bit is taken on a rising clock edge only when mode is 3'b111 or 3'b011, init_ready_i is high and configured_o is low. Taken bits are packed MSB-first: the first bit of a word ends up in bit WORD_W-1. After the edge that takes the WORD_W-th bit of a word, cfg_valid_o is high for exactly one cycle with that word on cfg_word_o. cfg_valid_o never rises once configured_o is high.
- R2: If CFG_BITS is not a multiple of WORD_W, the last taken bit flushes a partial word. That word is right-aligned, with its first bit in the highest occupied position and zeros above it, and it comes with a single cfg_valid_o pulse.
- R3: configured_o goes high after the edge that takes the CFG_BITS-th bit and stays high until reset.
- R4: While configured_o is low, dout_o is 0.
- R5: While configured_o is high and the mode is slave-serial, dout_o after each rising edge equals din_i sampled at that edge. dout_o changes only on rising edges.
- R6: Any other mode code is ignored. No bit is taken, packing and counting do not advance, and once configured_o is high dout_o holds its value.
- R7: While init_ready_i is low and configured_o is low, no bit is taken.
- R8: The asynchronous active-low reset clears the bit count, configured_o, dout_o and cfg_valid_o, and discards any partly filled word.
- R9: When dout_o feeds a second instance, that instance receives the bits that follow this device's CFG_BITS taken bits, bit-exact and one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Externally supplied configuration clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Mode select {M2,M1,M0}; 111 or 011 selects slave-serial |
| init_ready_i | input | 1 | Chain-wide init-ready; high allows loading |
| din_i | input | 1 | Serial configuration data |
| dout_o | output | 1 | Serial data toward the next device |
| configured_o | output | 1 | Own configuration complete |
| cfg_word_o | output | WORD_W | Packed configuration word |
| cfg_valid_o | output | 1 | One-cycle strobe for cfg_word_o |

## Verification
The bench targets the edge where the last own bit is taken. A counter that is off by one would forward one bit too early or too late, and the downstream instance would then see its stream shifted. It also targets the short final word: a packer that left-aligns the word or never flushes it would give a wrong or missing last strobe. Invalid mode codes and a low init-ready are applied both during loading and after it. A design that gated on only one mode bit, or ignored init-ready, would advance its word. A design that forwarded in a wrong mode would change dout_o. A reset in mid-load checks that a stale partial word does not leak into the next load.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;
  localparam logic [2:0] MODE_SER_A = 3'b111;
  localparam logic [2:0] MODE_SER_B = 3'b011;

  function automatic logic is_slave_serial(logic [2:0] mode);
    return (mode == MODE_SER_A) || (mode == MODE_SER_B);
  endfunction
endpackage

// File: rtl/cfg_mode_decode.sv
module cfg_mode_decode (
  input  logic [2:0] mode_i,
  output logic       slave_o
);
  import cfg_chain_pkg::*;
  // open pins are pulled up off-chip and arrive here as 1
  assign slave_o = is_slave_serial(mode_i);
endmodule

// File: rtl/cfg_bit_counter.sv
module cfg_bit_counter #(
  parameter int unsigned CFG_BITS = 3430400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  output logic last_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(CFG_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CFG_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign last_o = take_i && (cnt_q == LAST_IDX);
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (take_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_o) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_word_packer.sv
module cfg_word_packer #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              din_i,
  input  logic              flush_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  localparam int unsigned FILL_W = $clog2(WORD_W + 1);
  localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(WORD_W - 1);

  logic [WORD_W-1:0] acc_q, acc_nxt, word_q;
  logic [FILL_W-1:0] fill_q;
  logic              valid_q, emit;

  assign acc_nxt = {acc_q[WORD_W-2:0], din_i};
  assign emit    = take_i && ((fill_q == FILL_LAST) || flush_i);
  assign word_o  = word_q;
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      fill_q  <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= emit;
      if (emit) begin
        word_q <= acc_nxt;
        acc_q  <= '0;
        fill_q <= '0;
      end else if (take_i) begin
        acc_q  <= acc_nxt;
        fill_q <= fill_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_pass_stage.sv
module cfg_pass_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic fwd_i,
  input  logic din_i,
  output logic dout_o
);
  logic dout_q;
  assign dout_o = dout_q;

  // rising-edge launch keeps one full period for the downstream setup
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dout_q <= 1'b0;
    else if (!active_i) dout_q <= 1'b0;
    else if (fwd_i)     dout_q <= din_i;
  end
endmodule

// File: rtl/cfg_chain_rx.sv
module cfg_chain_rx #(
  parameter int unsigned CFG_BITS = 3430400,
  parameter int unsigned WORD_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              init_ready_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              configured_o,
  output logic [WORD_W-1:0] cfg_word_o,
  output logic              cfg_valid_o
);
  logic slave, take, last, done;

  cfg_mode_decode u_mode (.mode_i(mode_i), .slave_o(slave));

  assign take = slave && init_ready_i && !done;

  cfg_bit_counter #(.CFG_BITS(CFG_BITS)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take), .last_o(last), .done_o(done)
  );

  cfg_word_packer #(.WORD_W(WORD_W)) u_pack (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take), .din_i(din_i),
    .flush_i(last), .word_o(cfg_word_o), .valid_o(cfg_valid_o)
  );

  cfg_pass_stage u_pass (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(done), .fwd_i(slave),
    .din_i(din_i), .dout_o(dout_o)
  );

  assign configured_o = done;
endmodule

// File: rtl/cfg_chain_rx_chk.sv
module cfg_chain_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_i,
  input logic       init_ready_i,
  input logic       din_i,
  input logic       dout_o,
  input logic       configured_o,
  input logic       cfg_valid_o
);
  import cfg_chain_pkg::*;
  logic ser_ok;
  assign ser_ok = is_slave_serial(mode_i);

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !configured_o |-> !dout_o); // R4
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    configured_o |=> configured_o); // R3
  AST_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (configured_o && ser_ok) |=> (dout_o == $past(din_i))); // R5
  AST_HOLD_BAD_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (configured_o && !ser_ok) |=> $stable(dout_o)); // R6
  AST_NO_TAKE_BAD_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!configured_o && !ser_ok) |=> !cfg_valid_o); // R6
  AST_NO_TAKE_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!configured_o && !init_ready_i) |=> !cfg_valid_o); // R7
  AST_NO_WORD_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    configured_o |=> !cfg_valid_o); // R1
endmodule

bind cfg_chain_rx cfg_chain_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .init_ready_i(init_ready_i),
  .din_i(din_i), .dout_o(dout_o), .configured_o(configured_o),
  .cfg_valid_o(cfg_valid_o)
);

// File: tb/cfg_chain_rx_tb.sv
module cfg_chain_rx_tb;
  localparam int N1 = 20;
  localparam int N2 = 12;
  localparam int W  = 8;

  typedef struct {
    int         cnt;
    int         fill;
    logic [31:0] acc;
    logic [31:0] wout;
    logic       valid;
    logic       dout;
    logic       cfg;
  } mdl_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'b111;
  logic init = 1'b0;
  logic din = 1'b0;
  logic dout1, cfg1, val1, dout2, cfg2, val2;
  logic [W-1:0] word1, word2;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  mdl_t m1, m2;

  always #2.5 clk = ~clk;

  cfg_chain_rx #(.CFG_BITS(N1), .WORD_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .init_ready_i(init), .din_i(din),
    .dout_o(dout1), .configured_o(cfg1), .cfg_word_o(word1), .cfg_valid_o(val1)
  );
  cfg_chain_rx #(.CFG_BITS(N2), .WORD_W(W)) u_dn (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(3'b011), .init_ready_i(1'b1), .din_i(dout1),
    .dout_o(dout2), .configured_o(cfg2), .cfg_word_o(word2), .cfg_valid_o(val2)
  );

  function automatic logic mode_ok(logic [2:0] m);
    return (m == 3'b111) || (m == 3'b011);
  endfunction

  function automatic mdl_t mdl_clear();
    mdl_t r;
    r.cnt = 0; r.fill = 0; r.acc = 0; r.wout = 0;
    r.valid = 0; r.dout = 0; r.cfg = 0;
    return r;
  endfunction

  function automatic mdl_t mdl_step(mdl_t m, logic d, logic mok, logic ini, int n);
    mdl_t r = m;
    r.valid = 1'b0;
    if (m.cnt == n) begin
      if (mok) r.dout = d;
    end else begin
      r.dout = 1'b0;
      if (mok && ini) begin
        r.acc = (m.acc << 1) | 32'(d);
        r.fill++;
        r.cnt++;
        if (r.fill == W || r.cnt == n) begin
          r.valid = 1'b1; r.wout = r.acc; r.acc = 0; r.fill = 0;
        end
      end
    end
    r.cfg = (r.cnt == n);
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(logic d, logic [2:0] m, logic ini);
    mdl_t n1, n2;
    string t;
    logic ok = mode_ok(m);
    din = d; mode = m; init = ini;
    n1 = mdl_step(m1, d, ok, ini, N1);
    n2 = mdl_step(m2, m1.dout, 1'b1, 1'b1, N2);
    @(posedge clk);
    @(negedge clk);
    t = !ok ? "R6" : (!ini && !m1.cfg) ? "R7" : "R1";
    check("R3 configured", 32'(cfg1), 32'(n1.cfg));
    if (!n1.cfg) check("R4 idle dout", 32'(dout1), 0);
    else check(ok ? "R5 forward" : "R6 hold", 32'(dout1), 32'(n1.dout));
    check({t, " valid"}, 32'(val1), 32'(n1.valid));
    if (n1.valid && val1)
      check(n1.cfg ? "R2 last word" : "R1 word", 32'(word1), n1.wout);
    check("R9 dn configured", 32'(cfg2), 32'(n2.cfg));
    check("R9 dn dout", 32'(dout2), 32'(n2.dout));
    check("R9 dn valid", 32'(val2), 32'(n2.valid));
    if (n2.valid && val2) check("R9 dn word", 32'(word2), n2.wout);
    m1 = n1; m2 = n2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    m1 = mdl_clear(); m2 = mdl_clear();
    check("R8 dout", 32'(dout1), 0);
    check("R8 configured", 32'(cfg1), 0);
    check("R8 valid", 32'(val1), 0);
    check("R8 dn configured", 32'(cfg2), 0);
    rst_n = 1'b1;
  endtask

  task automatic rand_run(int len);
    for (int i = 0; i < len; i++) begin
      logic [2:0] m;
      int r = $urandom_range(0, 9);
      m = (r < 4) ? 3'b111 : (r < 8) ? 3'b011 : 3'($urandom_range(0, 7));
      cyc(1'($urandom), m, ($urandom_range(0, 7) != 0));
    end
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m1 = mdl_clear(); m2 = mdl_clear();
    do_reset();
    // R7: init low, ones offered but none taken
    for (int i = 0; i < 3; i++) cyc(1'b1, 3'b111, 1'b0);
    // R6: non slave-serial codes ignored while loading
    cyc(1'b1, 3'b010, 1'b1);
    cyc(1'b1, 3'b110, 1'b1);
    cyc(1'b1, 3'b000, 1'b1);
    // R1: known first word 0xA5
    for (int i = 7; i >= 0; i--) cyc(1'(8'hA5 >> i), 3'b011, 1'b1);
    // R2/R3: finish the 20 own bits then pass-through
    for (int i = 0; i < 12; i++) cyc(1'(i % 3 == 0), 3'b111, 1'b1);
    check("R3 configured at count", 32'(cfg1), 1);
    // R6 after configured: dout holds
    cyc(1'b1, 3'b111, 1'b1);
    cyc(1'b0, 3'b001, 1'b1);
    cyc(1'b0, 3'b101, 1'b0);
    rand_run(60);
    // R8: reset during a partial load, then reload
    do_reset();
    for (int i = 0; i < 5; i++) cyc(1'b1, 3'b111, 1'b1);
    do_reset();
    rand_run(150);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule